// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation-cache miss. It walks a two-level table tree in hardware. The bench or the surrounding logic gives it the frame number of the root table and a request made of an address, a write flag and a user-mode flag. The walker reads the root entry from memory and, unless that entry maps a 4 MB page, it then reads the second-level entry. It then checks the permissions, writes back the accessed and dirty bits that need setting, and reports either a translation or a fault with a cause code.

Each table holds 1024 entries of 4 bytes. The virtual address splits, from the top down, into a 10-bit root index, a 10-bit leaf index and a 12-bit page offset. Entry bits used by the walker:

| Bit | Meaning |
|-----|---------|
| 0 | present |
| 1 | writable |
| 2 | user |
| 5 | accessed |
| 6 | dirty (leaf only) |
| 7 | 4 MB page (root only) |
| 31..12 | frame number |

The walker handles one request at a time. On success the result feeds the translation-cache fill path directly, with no software involved.

Top module: `ptw_walker`

## Requirements
- R1: A request is accepted when `req_valid` is high and `busy` is low. The first memory read targets `{root_frame, 12'h000} + 4*vaddr[31:22]`.
- R2: If the root entry is present and bit 7 is clear, the second read targets `{root_entry[31:12], 12'h000} + 4*vaddr[21:12]`. A successful result then gives `done_paddr = {leaf[31:12], vaddr[11:0]}` and `done_large = 0`.
- R3: If the root entry is present and bit 7 is set, no second read is made. A successful result then gives `done_paddr = {root[31:22], vaddr[21:0]}` and `done_large = 1`.
- R4: If bit 0 is clear in the root entry, or in the leaf entry, the result is a fault with `done_cause = 2'b01`. In that case `done_paddr = 0` and nothing is written to memory. Presence is checked before permissions.
- R5: The effective writable and user rights are the AND of bits 1 and 2 over the entries used. A write without writable rights, or a user access without user rights, gives a fault with `done_cause = 2'b10`, and nothing is written to memory.
- R6: On success, an entry whose bit 5 is clear is written back with bit 5 set, the root entry before the leaf entry. An entry that needs no change is not written.
- R7: A successful write access sets bit 6 in the leaf entry. A 4 MB page's root entry never gets bit 6 from the walker, and a read never sets bit 6.
- R8: `busy` stays high from the cycle after acceptance through the single cycle in which `done_valid` is high, and falls in the next cycle. A `req_valid` raised while busy has no effect on the result.
- R9: A memory request holds its valid, address, write flag and data until `mem_req_ready`. A read finishes when `mem_rsp_valid` arrives, after any latency. A write finishes on acceptance.
- R10: On success, `done_cause = 2'b00`, `done_fault = 0`, and `done_pte` equals the final-level entry as it stands after the write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_frame | input | 20 | Frame number of the root table |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Result is a fault |
| done_cause | output | 2 | 00 ok, 01 not present, 10 protection |
| done_paddr | output | 32 | Physical address, zero on fault |
| done_pte | output | 32 | Final entry after write-back |
| done_large | output | 1 | Translation maps a 4 MB page |

## Verification
The assertions rely on these conditions at the memory port:
- Memory returns exactly one response per accepted read, and only after accepting it.
- Memory never responds to a write.
- Memory never raises a response when no read is outstanding.

The bench responder meets these conditions. It keeps at most one read in flight, randomises `mem_req_ready` each cycle, and returns data after one to four cycles. Root tables and leaf tables sit in separate address regions, so a walk never reads or writes the same word at both levels. This lets the reference walk predict every memory word independently.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int IDX_W   = 10;
  localparam int OFF_W   = 12;
  localparam int FRAME_W = VA_W - OFF_W;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_BIG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ROOT, ST_RD_LEAF, ST_UPDATE, ST_DONE, ST_FAULT
  } walk_st_e;

  typedef enum logic [1:0] {
    CZ_OK     = 2'b00,
    CZ_ABSENT = 2'b01,
    CZ_PROT   = 2'b10
  } cause_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-OFF_W-1:0] root_frame,
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-OFF_W-1:0] root_entry_frame,
  input  logic [VA_W-OFF_W-1:0] leaf_entry_frame,
  input  logic                  is_big,
  output logic [VA_W-1:0]       root_addr,
  output logic [VA_W-1:0]       leaf_addr,
  output logic [VA_W-1:0]       phys_addr
);
  localparam int BIG_OFF = OFF_W + IDX_W;
  localparam int ENT_SH  = 2;

  logic [IDX_W-1:0] root_idx, leaf_idx;
  logic [VA_W-1:0]  root_ofs, leaf_ofs;

  assign root_idx = vaddr[VA_W-1 -: IDX_W];
  assign leaf_idx = vaddr[OFF_W +: IDX_W];
  assign root_ofs = {{(VA_W-IDX_W){1'b0}}, root_idx} << ENT_SH;
  assign leaf_ofs = {{(VA_W-IDX_W){1'b0}}, leaf_idx} << ENT_SH;

  assign root_addr = {root_frame, {OFF_W{1'b0}}} + root_ofs;
  assign leaf_addr = {root_entry_frame, {OFF_W{1'b0}}} + leaf_ofs;

  always_comb begin
    if (is_big)
      phys_addr = {root_entry_frame[VA_W-OFF_W-1:IDX_W], vaddr[BIG_OFF-1:0]};
    else
      phys_addr = {leaf_entry_frame, vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] root_pte,
  input  logic [PTE_W-1:0] leaf_pte,
  input  logic             is_write,
  input  logic             is_user,
  output logic             prot_fault,
  output logic             root_upd,
  output logic             leaf_upd,
  output logic [PTE_W-1:0] root_new,
  output logic [PTE_W-1:0] leaf_new
);
  localparam logic [PTE_W-1:0] ACC_M = {{(PTE_W-1){1'b0}}, 1'b1} << B_ACC;
  localparam logic [PTE_W-1:0] DRT_M = {{(PTE_W-1){1'b0}}, 1'b1} << B_DIRTY;

  logic big, wr_ok, usr_ok;

  assign big    = root_pte[B_BIG];
  assign wr_ok  = root_pte[B_WR]  & (big | leaf_pte[B_WR]);
  assign usr_ok = root_pte[B_USR] & (big | leaf_pte[B_USR]);

  assign prot_fault = (is_write & ~wr_ok) | (is_user & ~usr_ok);

  assign root_new = root_pte | ACC_M;
  assign root_upd = ~root_pte[B_ACC];

  assign leaf_new = leaf_pte | ACC_M | (is_write ? DRT_M : '0);
  assign leaf_upd = ~big & (leaf_new != leaf_pte);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int FR_W = VA_W - OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FR_W-1:0] root_frame,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [VA_W-1:0] mem_req_addr,
  output logic [VA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_rdata,
  output logic            done_valid,
  output logic            done_fault,
  output logic [1:0]      done_cause,
  output logic [VA_W-1:0] done_paddr,
  output logic [VA_W-1:0] done_pte,
  output logic            done_large
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  walk_st_e        st, st_d;
  cause_e          cause_q, cause_d;
  logic            pend, pend_d;
  logic            root_wr_done, root_wr_done_d;
  logic [VA_W-1:0] va_q, root_q, leaf_q;
  logic [FR_W-1:0] base_q;
  logic            wr_q, usr_q;
  logic            cap_req, cap_root, cap_leaf;

  logic [VA_W-1:0] root_addr, leaf_addr, phys_addr, root_new, leaf_new;
  logic            prot_fault, root_upd, leaf_upd, is_big;

  assign is_big = root_q[B_BIG];

  ptw_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .root_frame       (base_q),
    .vaddr            (va_q),
    .root_entry_frame (root_q[VA_W-1:OFF_W]),
    .leaf_entry_frame (leaf_q[VA_W-1:OFF_W]),
    .is_big           (is_big),
    .root_addr        (root_addr),
    .leaf_addr        (leaf_addr),
    .phys_addr        (phys_addr)
  );

  ptw_perm_check #(.PTE_W(VA_W)) u_perm (
    .root_pte   (root_q),
    .leaf_pte   (leaf_q),
    .is_write   (wr_q),
    .is_user    (usr_q),
    .prot_fault (prot_fault),
    .root_upd   (root_upd),
    .leaf_upd   (leaf_upd),
    .root_new   (root_new),
    .leaf_new   (leaf_new)
  );

  // Next-state logic.
  always_comb begin
    st_d           = st;
    cause_d        = cause_q;
    pend_d         = pend;
    root_wr_done_d = root_wr_done;
    cap_req        = 1'b0;
    cap_root       = 1'b0;
    cap_leaf       = 1'b0;
    mem_req_valid  = 1'b0;
    mem_req_we     = 1'b0;
    mem_req_addr   = root_addr;
    mem_req_wdata  = '0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req        = 1'b1;
          pend_d         = 1'b0;
          root_wr_done_d = 1'b0;
          cause_d        = CZ_OK;
          st_d           = ST_RD_ROOT;
        end
      end
      ST_RD_ROOT: begin
        mem_req_valid = ~pend;
        mem_req_addr  = root_addr;
        if (mem_req_valid && mem_req_ready) pend_d = 1'b1;
        if (pend && mem_rsp_valid) begin
          cap_root = 1'b1;
          pend_d   = 1'b0;
          if (!mem_rsp_rdata[B_PRES]) begin
            cause_d = CZ_ABSENT;
            st_d    = ST_FAULT;
          end else if (mem_rsp_rdata[B_BIG]) begin
            st_d = ST_UPDATE;
          end else begin
            st_d = ST_RD_LEAF;
          end
        end
      end
      ST_RD_LEAF: begin
        mem_req_valid = ~pend;
        mem_req_addr  = leaf_addr;
        if (mem_req_valid && mem_req_ready) pend_d = 1'b1;
        if (pend && mem_rsp_valid) begin
          cap_leaf = 1'b1;
          pend_d   = 1'b0;
          if (!mem_rsp_rdata[B_PRES]) begin
            cause_d = CZ_ABSENT;
            st_d    = ST_FAULT;
          end else begin
            st_d = ST_UPDATE;
          end
        end
      end
      ST_UPDATE: begin
        if (prot_fault) begin
          cause_d = CZ_PROT;
          st_d    = ST_FAULT;
        end else if (root_upd && !root_wr_done) begin
          mem_req_valid = 1'b1;
          mem_req_we    = 1'b1;
          mem_req_addr  = root_addr;
          mem_req_wdata = root_new;
          if (mem_req_ready) root_wr_done_d = 1'b1;
        end else if (leaf_upd) begin
          mem_req_valid = 1'b1;
          mem_req_we    = 1'b1;
          mem_req_addr  = leaf_addr;
          mem_req_wdata = leaf_new;
          if (mem_req_ready) st_d = ST_DONE;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      st           <= ST_IDLE;
      cause_q      <= CZ_OK;
      pend         <= 1'b0;
      root_wr_done <= 1'b0;
    end else begin
      st           <= st_d;
      cause_q      <= cause_d;
      pend         <= pend_d;
      root_wr_done <= root_wr_done_d;
    end
  end

  // Datapath registers with explicit enables.
  always_ff @(posedge clk) begin
    if (cap_req) begin
      va_q   <= req_vaddr;
      base_q <= root_frame;
      wr_q   <= req_write;
      usr_q  <= req_user;
    end
    if (cap_root) root_q <= mem_rsp_rdata;
    if (cap_leaf) leaf_q <= mem_rsp_rdata;
  end

  assign busy       = (st != ST_IDLE);
  assign done_valid = (st == ST_DONE) || (st == ST_FAULT);
  assign done_fault = (st == ST_FAULT);
  assign done_cause = cause_q;
  assign done_paddr = (st == ST_DONE) ? phys_addr : '0;
  assign done_pte   = (st == ST_DONE) ? (is_big ? root_new : leaf_new) : '0;
  assign done_large = (st == ST_DONE) && is_big;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R6
  acc_set_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[B_ACC]);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $fell(busy) |-> $past(done_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done_valid |=> !done_valid && !busy);

  // R3
  big_ofs_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done_valid && done_large |-> done_paddr[OFF_W+IDX_W-1:0] == va_q[OFF_W+IDX_W-1:0]);

  // R4
  fault_nomap_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done_valid && done_fault |-> done_paddr == '0 && done_cause != CZ_OK);
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done_valid, done_fault, done_large;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr, done_pte;

  always #5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_fault(done_fault), .done_cause(done_cause),
    .done_paddr(done_paddr), .done_pte(done_pte), .done_large(done_large)
  );

  // Memory model: owns the array, takes bench setup writes and walker traffic.
  logic [31:0] mem [logic [31:0]];
  logic        bd_we = 1'b0, bd_clr = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  logic [31:0] hold = '0;
  int          lat = 0;
  int          wr_total = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= ($urandom_range(0, 3) != 0);
    if (bd_clr) mem.delete();
    else if (bd_we) mem[bd_addr] = bd_data;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= hold;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_total <= wr_total + 1;
      end else begin
        hold <= rd(mem_req_addr);
        lat  <= $urandom_range(1, 4);
      end
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic wipe();
    @(negedge clk); bd_clr = 1'b1;
    @(negedge clk); bd_clr = 1'b0;
  endtask

  function automatic logic [31:0] root_at(input logic [19:0] rf, input logic [31:0] va);
    return {rf, 12'h000} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] leaf_at(input logic [31:0] re, input logic [31:0] va);
    return {re[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  // Reference walk and comparison.
  task automatic walk(input logic [19:0] rf, input logic [31:0] va, input bit wr, input bit usr,
                      input bit glitch, input string rq);
    logic [31:0] ra, la, re, le, re_n, le_n, pa, pte;
    logic [1:0]  cause;
    bit          big, w_ok, u_ok;
    int          nwr, w0, cyc;
    ra = root_at(rf, va); re = rd(ra);
    la = leaf_at(re, va); le = rd(la);
    big = re[7]; re_n = re; le_n = le; nwr = 0; pa = 0; pte = 0;
    if (!re[0] || (!big && !le[0])) cause = 2'b01;
    else begin
      w_ok = re[1] & (big | le[1]);
      u_ok = re[2] & (big | le[2]);
      if ((wr && !w_ok) || (usr && !u_ok)) cause = 2'b10;
      else begin
        cause = 2'b00;
        re_n = re | 32'h20;
        if (!re[5]) nwr++;
        if (!big) begin
          le_n = le | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (le_n != le) nwr++;
          pa = {le[31:12], va[11:0]}; pte = le_n;
        end else begin
          pa = {re[31:22], va[21:0]}; pte = re_n;
        end
      end
    end
    w0 = wr_total;
    @(negedge clk);
    root_frame = rf; req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "busy after accept", {31'h0, busy}, 32'h1);
    cyc = 0;
    while (!done_valid && cyc < 2000) begin
      if (glitch && cyc == 0) begin
        req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr; req_user = ~usr;
      end
      if (glitch && cyc == 2) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (cyc >= 2000) chk(rq, "watchdog expired", 32'h1, 32'h0);
    chk(rq, "cause (R4 R5 R10)", {30'h0, done_cause}, {30'h0, cause});
    chk(rq, "fault flag", {31'h0, done_fault}, {31'h0, (cause != 2'b00)});
    chk(rq, "paddr (R2 R3 R4)", done_paddr, pa);
    if (cause == 2'b00) begin
      chk(rq, "large flag R3", {31'h0, done_large}, {31'h0, big});
      chk(rq, "final entry R10", done_pte, pte);
    end
    @(negedge clk);
    chk("R8", "done is one pulse", {31'h0, done_valid}, 32'h0);
    chk("R8", "busy drops after done", {31'h0, busy}, 32'h0);
    chk(rq, "root word after walk R6", rd(ra), re_n);
    if (!big && re[0]) chk(rq, "leaf word after walk R6 R7", rd(la), le_n);
    chk(rq, "write count R6", wr_total - w0, nwr);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL R8 global watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [19:0] rf;
    logic [31:0] va, re, le;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "reset busy", {31'h0, busy}, 32'h0);
    chk("R9", "reset mem valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R8", "reset done", {31'h0, done_valid}, 32'h0);

    // R4: root entry absent.
    rf = 20'h00120; va = 32'h1234_5678;
    wipe(); put(root_at(rf, va), 32'h0020_3006);
    walk(rf, va, 1'b0, 1'b0, 1'b0, "R4");
    // R4: leaf entry absent.
    re = 32'h0020_4007; put(root_at(rf, va), re);
    put(leaf_at(re, va), 32'h0ABC_D006);
    walk(rf, va, 1'b0, 1'b0, 1'b0, "R4");
    // R1 R2 R7: leaf write, accessed and dirty set.
    wipe(); put(root_at(rf, va), re); put(leaf_at(re, va), 32'h0ABC_D007);
    walk(rf, va, 1'b1, 1'b1, 1'b0, "R2");
    // R6: same walk again, nothing changes, no writes.
    walk(rf, va, 1'b1, 1'b1, 1'b0, "R6");
    // R3 R7: 4 MB page write, no dirty on root.
    wipe(); put(root_at(rf, va), 32'h0C40_0087);
    walk(rf, va, 1'b1, 1'b0, 1'b0, "R3");
    // R5: write to read-only leaf.
    wipe(); put(root_at(rf, va), re); put(leaf_at(re, va), 32'h0ABC_D005);
    walk(rf, va, 1'b1, 1'b0, 1'b0, "R5");
    // R5: user access, root lacks user right.
    wipe(); put(root_at(rf, va), 32'h0020_4003); put(leaf_at(32'h0020_4003, va), 32'h0ABC_D007);
    walk(rf, va, 1'b0, 1'b1, 1'b0, "R5");
    // R8: request raised while busy is ignored.
    wipe(); put(root_at(rf, va), re); put(leaf_at(re, va), 32'h0ABC_D003);
    walk(rf, va, 1'b0, 1'b0, 1'b1, "R8");

    // Random walks (R1 R2 R3 R9).
    for (int i = 0; i < 150; i++) begin
      rf = 20'h00100 + 20'($urandom_range(0, 255));
      va = $urandom();
      re = {20'h00200 + 20'($urandom_range(0, 4095)), 12'($urandom())};
      re[0] = ($urandom_range(0, 7) != 0);
      re[1] = ($urandom_range(0, 3) != 0);
      re[2] = ($urandom_range(0, 3) != 0);
      re[7] = ($urandom_range(0, 3) == 0);
      le = $urandom();
      le[0] = ($urandom_range(0, 7) != 0);
      le[1] = ($urandom_range(0, 3) != 0);
      le[2] = ($urandom_range(0, 3) != 0);
      wipe();
      put(root_at(rf, va), re);
      put(leaf_at(re, va), le);
      walk(rf, va, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule